// File: doc/BRIEF.md
# Dual-Length Pseudo-Random Bit Source

This block produces an endless, periodic pseudo-random bit stream for exercising a data link. A mode input picks one of two lengths: a short pattern that repeats every 15 bits, and a long pattern that repeats every 255 bits. The short one suits an oscilloscope display. The long one is closer to random data and suits error-rate counting.

The stream advances only on a bit-enable pulse, so it stays in step with the transmit bit timing. Between pulses the output bit holds steady.

Alongside each bit the block gives a one-cycle period marker. The marker is high together with the first bit of every period, so it can trigger a scope or align a receiving checker. A change of the mode input restarts the chosen pattern from a fixed non-zero seed. The all-zero lock-up state therefore cannot occur.

Top module: `prbs_dual_src`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `bit_o` is 0, `frame_o` is 0, `len_o` equals `len_sel` and both generators hold the seed of all ones.
- R2: Short mode (`len_sel` = 0) uses a 4-bit shift register. The emitted bit is bit 3 of the state before the step. The next state is the state shifted left by one, with bit 3 XOR bit 2 entering at bit 0 (polynomial x^4+x^3+1). The seed is 4'b1111, and the pattern has period 15.
- R3: Long mode (`len_sel` = 1) uses an 8-bit shift register. The emitted bit is bit 7 of the state before the step. The next state is the state shifted left by one, with bits 7, 5, 4 and 3 XORed into bit 0 (polynomial x^8+x^6+x^5+x^4+1). The seed is 8'hFF, and the pattern has period 255.
- R4: `bit_o` changes only in the cycle after a clock edge where `bit_en` was high and no restart took place. In every other cycle it keeps its value.
- R5: `frame_o` is high for exactly one cycle, together with the emitted bit that is the first of a period, counted from reset or from the last restart. It is low in all other cycles.
- R6: When `len_sel` differs from `len_o` at a clock edge (a restart), after that edge `len_o` equals `len_sel`, both generators are reseeded, the period position returns to its start, `frame_o` is 0 and `bit_o` is held.
- R7: A `bit_en` pulse in the same cycle as a restart is ignored. The next enabled bit after a restart is the first bit of the period and carries `frame_o`.
- R8: Over one full period, short mode emits 8 ones and 7 zeros, and long mode emits 128 ones and 127 zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-clock enable; one bit is emitted per high cycle |
| len_sel | input | 1 | Pattern length: 0 selects 15, 1 selects 255 |
| bit_o | output | 1 | Current pseudo-random data bit |
| frame_o | output | 1 | One-cycle marker on the first bit of each period |
| len_o | output | 1 | Length mode currently in effect |

## Verification
A restart and a bit-enable pulse can fall on the same clock edge. The bench provokes this by raising `bit_en` in the same cycle that `len_sel` is flipped. It then judges three things: the data bit must stay held, the marker must stay low, and the following enabled bit must be the first of the new period with the marker raised. A behavioural reference model is compared on every cycle, while the enable pattern alternates between dense, sparse and gapped runs in both modes.

// File: rtl/prbs_src_pkg.sv
package prbs_src_pkg;

    typedef enum logic {
        LEN_SHORT = 1'b0,
        LEN_LONG  = 1'b1
    } len_mode_e;

    localparam int SHORT_W = 4;
    localparam int LONG_W  = 8;
    localparam int POS_W   = LONG_W;

    localparam logic [SHORT_W-1:0] SHORT_TAPS = 4'b1100;
    localparam logic [LONG_W-1:0]  LONG_TAPS  = 8'b1011_1000;
    localparam logic [SHORT_W-1:0] SHORT_SEED = '1;
    localparam logic [LONG_W-1:0]  LONG_SEED  = '1;

    localparam int SHORT_PERIOD = (1 << SHORT_W) - 1;
    localparam int LONG_PERIOD  = (1 << LONG_W) - 1;

    typedef struct packed {
        logic      data;
        logic      frame;
        len_mode_e len;
    } src_regs_t;

    function automatic logic [POS_W-1:0] last_pos(len_mode_e m);
        if (m == LEN_LONG) begin
            return POS_W'(LONG_PERIOD - 1);
        end
        return POS_W'(SHORT_PERIOD - 1);
    endfunction

endpackage

// File: rtl/prbs_lfsr.sv
module prbs_lfsr #(
    parameter int           W    = 4,
    parameter logic [W-1:0] TAPS = 4'b1100,
    parameter logic [W-1:0] SEED = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    output logic [W-1:0] state_o,
    output logic         msb_o
);

    logic [W-1:0] state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = SEED;
        end else if (step) begin
            state_d = {state_q[W-2:0], ^(state_q & TAPS)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;
    assign msb_o   = state_q[W-1];

    // R2 / R3: a maximal register never reaches the all-zero state
    p_no_lockup_r2: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

    // R3: a load always lands on the seed
    p_load_seed_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> state_q == SEED);

endmodule

// File: rtl/prbs_phase_ctr.sv
module prbs_phase_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] last_i,
    output logic [W-1:0] count_o,
    output logic         at_start_o
);

    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clear) begin
            count_d = '0;
        end else if (step) begin
            count_d = (count_q >= last_i) ? '0 : count_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count_o    = count_q;
    assign at_start_o = (count_q == '0);

    // R5: the position never leaves the period of the active mode
    p_pos_in_range_r5: assert property (@(posedge clk) disable iff (rst)
        count_q <= last_i);

    // R6: a clear returns the position to the start
    p_clear_start_r6: assert property (@(posedge clk) disable iff (rst)
        clear |=> count_q == '0);

endmodule

// File: rtl/prbs_dual_src.sv
module prbs_dual_src
    import prbs_src_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic len_sel,
    output logic bit_o,
    output logic frame_o,
    output logic len_o
);

    src_regs_t d, q;

    logic restart, step;
    logic step_short, step_long, reload;
    logic [SHORT_W-1:0] short_state;
    logic [LONG_W-1:0]  long_state;
    logic short_bit, long_bit, cur_bit;
    logic [POS_W-1:0] pos;
    logic at_start;

    assign restart    = (len_mode_e'(len_sel) != q.len);
    assign step       = bit_en && !restart;
    assign reload     = rst || restart;
    assign step_short = step && (q.len == LEN_SHORT);
    assign step_long  = step && (q.len == LEN_LONG);
    assign cur_bit    = (q.len == LEN_LONG) ? long_bit : short_bit;

    prbs_lfsr #(
        .W    (SHORT_W),
        .TAPS (SHORT_TAPS),
        .SEED (SHORT_SEED)
    ) u_short (
        .clk     (clk),
        .rst     (rst),
        .load    (reload),
        .step    (step_short),
        .state_o (short_state),
        .msb_o   (short_bit)
    );

    prbs_lfsr #(
        .W    (LONG_W),
        .TAPS (LONG_TAPS),
        .SEED (LONG_SEED)
    ) u_long (
        .clk     (clk),
        .rst     (rst),
        .load    (reload),
        .step    (step_long),
        .state_o (long_state),
        .msb_o   (long_bit)
    );

    prbs_phase_ctr #(
        .W (POS_W)
    ) u_phase (
        .clk        (clk),
        .rst        (rst),
        .clear      (reload),
        .step       (step),
        .last_i     (last_pos(q.len)),
        .count_o    (pos),
        .at_start_o (at_start)
    );

    always_comb begin
        d       = q;
        d.frame = 1'b0;
        if (restart) begin
            d.len = len_mode_e'(len_sel);
        end else if (step) begin
            d.data  = cur_bit;
            d.frame = at_start;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{data: 1'b0, frame: 1'b0, len: len_mode_e'(len_sel)};
        end else begin
            q <= d;
        end
    end

    assign bit_o   = q.data;
    assign frame_o = q.frame;
    assign len_o   = q.len;

    // R4: without an accepted enable the data bit holds
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !($past(bit_en) && $past(len_sel) == $past(len_o)))
            |-> $stable(bit_o));

    // R5: a marker needs an enable on the previous edge
    p_frame_needs_en_r5: assert property (@(posedge clk) disable iff (rst)
        frame_o |-> $past(bit_en));

    // R5: the period start coincides with the seed of the active register
    p_start_is_seed_r5: assert property (@(posedge clk) disable iff (rst)
        (step_short && at_start) |-> short_state == SHORT_SEED);
    p_start_is_seed_long_r5: assert property (@(posedge clk) disable iff (rst)
        (step_long && at_start) |-> long_state == LONG_SEED);

    // R6 / R7: a restart suppresses the marker and adopts the new length
    p_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (len_sel != len_o) |=> (!frame_o && len_o == $past(len_sel)));

endmodule

// File: tb/prbs_dual_src_bench.sv
module prbs_dual_src_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0;
    logic len_sel = 1'b0;
    logic bit_o, frame_o, len_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    prbs_dual_src u_prbs_dual_src (
        .clk     (clk),
        .rst     (rst),
        .bit_en  (bit_en),
        .len_sel (len_sel),
        .bit_o   (bit_o),
        .frame_o (frame_o),
        .len_o   (len_o)
    );

    // reference model
    int  m_s, m_l, m_pos;
    logic m_data, m_frame, m_len;

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (rst) begin
            m_s = 15; m_l = 255; m_pos = 0;
            m_data = 0; m_frame = 0; m_len = len_sel;
        end else if (len_sel != m_len) begin
            m_s = 15; m_l = 255; m_pos = 0;
            m_frame = 0; m_len = len_sel;
        end else if (bit_en) begin
            m_frame = (m_pos == 0);
            if (m_len) begin
                m_data = (m_l >> 7) & 1;
                m_l = ((m_l << 1) | (((m_l >> 7) ^ (m_l >> 5) ^ (m_l >> 4) ^ (m_l >> 3)) & 1)) & 255;
                m_pos = (m_pos + 1) % 255;
            end else begin
                m_data = (m_s >> 3) & 1;
                m_s = ((m_s << 1) | (((m_s >> 3) ^ (m_s >> 2)) & 1)) & 15;
                m_pos = (m_pos + 1) % 15;
            end
        end else begin
            m_frame = 0;
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, R2 R3 R4 R5 R6
    always @(negedge clk) begin
        if (cycles > 0) begin
            check(bit_o === m_data, m_len ? "R3 data" : "R2 data", int'(bit_o), int'(m_data));
            check(frame_o === m_frame, "R5 frame", int'(frame_o), int'(m_frame));
            check(len_o === m_len, "R6 len", int'(len_o), int'(m_len));
        end
    end

    task automatic tick(input logic en, input logic sel);
        @(negedge clk);
        bit_en  = en;
        len_sel = sel;
        @(posedge clk);
        #1;
    endtask

    // one full period with given enable spacing; counts ones and markers
    task automatic run_period(input logic sel, input int period, input int gap,
                              input int exp_ones, input string req);
        int ones = 0;
        int frames = 0;
        for (int i = 0; i < period; i++) begin
            tick(1'b1, sel);
            if (i == 0) check(frame_o === 1'b1, "R5 first bit marker", int'(frame_o), 1);
            ones   = ones + int'(bit_o);
            frames = frames + int'(frame_o);
            for (int g = 0; g < gap; g++) begin
                tick(1'b0, sel);
                check(frame_o === 1'b0, "R5 marker one cycle", int'(frame_o), 0);
            end
        end
        check(ones == exp_ones, req, ones, exp_ones);
        check(frames == 1, "R5 one marker per period", frames, 1);
    endtask

    initial begin
        logic held;
        repeat (3) tick(1'b0, 1'b0);
        // R1 reset state
        check(bit_o === 1'b0, "R1 data", int'(bit_o), 0);
        check(frame_o === 1'b0, "R1 frame", int'(frame_o), 0);
        check(len_o === 1'b0, "R1 len", int'(len_o), 0);
        @(negedge clk);
        rst = 1'b0;
        tick(1'b0, 1'b0);

        // R2 / R8 short mode, sparse and dense enables
        run_period(1'b0, 15, 1, 8, "R8 short ones");
        run_period(1'b0, 15, 0, 8, "R8 short ones again");
        // R4 hold across a long gap
        held = bit_o;
        for (int i = 0; i < 5; i++) begin
            tick(1'b0, 1'b0);
            check(bit_o === held, "R4 hold", int'(bit_o), int'(held));
        end

        // R6 restart into long mode
        held = bit_o;
        tick(1'b0, 1'b1);
        check(len_o === 1'b1, "R6 len follows", int'(len_o), 1);
        check(bit_o === held, "R6 data held", int'(bit_o), int'(held));
        check(frame_o === 1'b0, "R6 no marker", int'(frame_o), 0);

        // R3 / R8 long mode
        run_period(1'b1, 255, 0, 128, "R8 long ones");
        run_period(1'b1, 255, 2, 128, "R8 long ones gapped");

        // R7 partial period, then restart on an enable cycle
        for (int i = 0; i < 40; i++) tick(1'b1, 1'b1);
        held = bit_o;
        tick(1'b1, 1'b0);
        check(bit_o === held, "R7 enable ignored on restart", int'(bit_o), int'(held));
        check(frame_o === 1'b0, "R7 no marker on restart", int'(frame_o), 0);
        tick(1'b1, 1'b0);
        check(frame_o === 1'b1, "R7 first bit after restart", int'(frame_o), 1);
        check(bit_o === 1'b1, "R7 seed first bit", int'(bit_o), 1);
        for (int i = 0; i < 20; i++) tick(1'b1, 1'b0);

        // R1 reset in mid-stream with long select
        @(negedge clk);
        rst = 1'b1;
        len_sel = 1'b1;
        tick(1'b1, 1'b1);
        check(len_o === 1'b1, "R1 len on reset", int'(len_o), 1);
        check(bit_o === 1'b0, "R1 data on reset", int'(bit_o), 0);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 30; i++) tick(i % 3 != 0, 1'b1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait (cycles >= 100000);
        checks = checks + 1;
        fails  = fails + 1;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule